// File: doc/BRIEF.md
# Register Lock Scoreboard

This block keeps one busy bit for each general register of a small in-order pipeline, and a separate busy bit for the status register. When the decode stage issues an instruction, it marks up to two destination registers busy in a single cycle. If the instruction also writes the status register, decode marks that bit busy as well. When results retire, the write-back stage clears up to two general register bits and the status register bit in the same cycle.

Decode presents two source register addresses and a status-register read flag, each with its own valid strobe. The block answers in the same cycle with a stall request. The stall request is raised when any valid source names a busy resource. While the stall request is high, no lock request takes effect. A stalled instruction therefore never marks a register busy twice, and it never locks a register too early. The busy vector is visible at the ports so the surrounding pipeline can observe it.

Top module: `reg_lock_board`

## Requirements
- R1: After reset, every general busy bit, the status busy bit and the stall output are 0.
- R2: When `lk0_vld` or `lk1_vld` is high and `stall` is low, the busy bit at index `lk0_reg` or `lk1_reg` is 1 from the next cycle on. Both ports can act in the same cycle, and no other bit changes because of them.
- R3: When `ul0_vld` or `ul1_vld` is high, the busy bit at index `ul0_reg` or `ul1_reg` is 0 from the next cycle on, unless R6 applies. Both ports can act in the same cycle.
- R4: `lk_sr` with `stall` low sets `sr_busy` in the next cycle, and `ul_sr` clears it. Neither one changes any general busy bit.
- R5: `stall` is combinational. It is 1 exactly when (`rd0_vld` and the busy bit at `rd0_reg`), or (`rd1_vld` and the busy bit at `rd1_reg`), or (`rd_sr` and `sr_busy`).
- R6: If a register is unlocked and locked in the same cycle, with `stall` low, its busy bit stays 1. The same holds for the status bit.
- R7: While `stall` is 1, `lk0_vld`, `lk1_vld` and `lk_sr` have no effect.
- R8: An unlock that names a register whose bit is already 0 leaves every busy bit unchanged.
- R9: An address whose valid strobe is low has no effect on the busy bits or on `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk0_vld | input | 1 | Lock port 0 valid |
| lk0_reg | input | 4 | Lock port 0 register index |
| lk1_vld | input | 1 | Lock port 1 valid |
| lk1_reg | input | 4 | Lock port 1 register index |
| lk_sr | input | 1 | Issuing instruction writes the status register |
| ul0_vld | input | 1 | Unlock port 0 valid |
| ul0_reg | input | 4 | Unlock port 0 register index |
| ul1_vld | input | 1 | Unlock port 1 valid |
| ul1_reg | input | 4 | Unlock port 1 register index |
| ul_sr | input | 1 | Status register result retires |
| rd0_vld | input | 1 | Source query 0 valid |
| rd0_reg | input | 4 | Source query 0 register index |
| rd1_vld | input | 1 | Source query 1 valid |
| rd1_reg | input | 4 | Source query 1 register index |
| rd_sr | input | 1 | Decode reads the status register |
| stall | output | 1 | Stall request to decode |
| busy | output | 16 | Busy bit per general register |
| sr_busy | output | 1 | Status register busy bit |

## Verification
The bench sets up collisions between the two ports.

- **Unlock and lock of the same register in one cycle.** If unlock took priority, the register would read as free while its write was still in flight.
- **A lock request while decode is stalled.** A design that ignored the stall would mark a register busy early. That register would block the instruction that retires it, or would later be unlocked while still needed.
- **A status-register lock.** The bench checks that this lock touches no general register bit, which is the mistake of locking the wrong register.
- **Strobes and stale unlocks.** The bench applies invalid strobes and unlocks of registers that are already free. A design that decoded addresses without checking the valid strobe would set or clear bits at random.

// File: rtl/reg_lock_board.sv
module reg_lock_board #(
  parameter int NUM_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk0_vld,
  input  logic [$clog2(NUM_REGS)-1:0] lk0_reg,
  input  logic                        lk1_vld,
  input  logic [$clog2(NUM_REGS)-1:0] lk1_reg,
  input  logic                        lk_sr,
  input  logic                        ul0_vld,
  input  logic [$clog2(NUM_REGS)-1:0] ul0_reg,
  input  logic                        ul1_vld,
  input  logic [$clog2(NUM_REGS)-1:0] ul1_reg,
  input  logic                        ul_sr,
  input  logic                        rd0_vld,
  input  logic [$clog2(NUM_REGS)-1:0] rd0_reg,
  input  logic                        rd1_vld,
  input  logic [$clog2(NUM_REGS)-1:0] rd1_reg,
  input  logic                        rd_sr,
  output logic                        stall,
  output logic [NUM_REGS-1:0]         busy,
  output logic                        sr_busy
);

  logic [NUM_REGS-1:0] busy_q;
  logic [NUM_REGS-1:0] set_mask;
  logic [NUM_REGS-1:0] clr_mask;
  logic                sr_q;
  logic                issue_ok;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_mask
    assign set_mask[i] = (lk0_vld && lk0_reg == i) || (lk1_vld && lk1_reg == i);
    assign clr_mask[i] = (ul0_vld && ul0_reg == i) || (ul1_vld && ul1_reg == i);
  end

  assign stall = (rd0_vld && busy_q[rd0_reg]) ||
                 (rd1_vld && busy_q[rd1_reg]) ||
                 (rd_sr && sr_q);

  assign issue_ok = !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      sr_q   <= 1'b0;
    end else begin
      busy_q <= (busy_q & ~clr_mask) | (issue_ok ? set_mask : '0);
      sr_q   <= (sr_q & ~ul_sr) | (issue_ok & lk_sr);
    end
  end

  assign busy    = busy_q;
  assign sr_busy = sr_q;

endmodule

// File: rtl/reg_lock_board_chk.sv
module reg_lock_board_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        lk0_vld,
  input logic [$clog2(NUM_REGS)-1:0] lk0_reg,
  input logic                        lk1_vld,
  input logic [$clog2(NUM_REGS)-1:0] lk1_reg,
  input logic                        lk_sr,
  input logic                        ul0_vld,
  input logic [$clog2(NUM_REGS)-1:0] ul0_reg,
  input logic                        ul1_vld,
  input logic [$clog2(NUM_REGS)-1:0] ul1_reg,
  input logic                        ul_sr,
  input logic                        rd0_vld,
  input logic [$clog2(NUM_REGS)-1:0] rd0_reg,
  input logic                        rd1_vld,
  input logic [$clog2(NUM_REGS)-1:0] rd1_reg,
  input logic                        rd_sr,
  input logic                        stall,
  input logic [NUM_REGS-1:0]         busy,
  input logic                        sr_busy
);

  a_r2_lock0_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lk0_vld && !stall |=> busy[$past(lk0_reg)]);

  a_r2_lock1_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lk1_vld && !stall |=> busy[$past(lk1_reg)]);

  a_r2_at_most_two_new: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(busy & ~$past(busy)) <= 2);

  a_r3_unlock0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ul0_vld && !(lk0_vld && lk0_reg == ul0_reg) && !(lk1_vld && lk1_reg == ul0_reg)
    |=> !busy[$past(ul0_reg)]);

  a_r4_sr_lock: assert property (@(posedge clk) disable iff (!rst_n)
    lk_sr && !stall |=> sr_busy);

  a_r5_stall_src0: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_vld && busy[rd0_reg] |-> stall);

  a_r5_no_query_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0_vld && !rd1_vld && !rd_sr |-> !stall);

  a_r6_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ul0_vld && lk1_vld && lk1_reg == ul0_reg && !stall |=> busy[$past(ul0_reg)]);

  a_r7_stall_no_new_lock: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (busy & ~$past(busy)) == '0 && !(sr_busy && !$past(sr_busy)));

endmodule

bind reg_lock_board reg_lock_board_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/reg_lock_board_tb.sv
module reg_lock_board_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic lk0_vld, lk1_vld, lk_sr, ul0_vld, ul1_vld, ul_sr, rd0_vld, rd1_vld, rd_sr;
  logic [3:0] lk0_reg, lk1_reg, ul0_reg, ul1_reg, rd0_reg, rd1_reg;
  logic stall, sr_busy;
  logic [15:0] busy;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  reg_lock_board u_dut (.*);

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    {lk0_vld, lk1_vld, lk_sr, ul0_vld, ul1_vld, ul_sr, rd0_vld, rd1_vld, rd_sr} = '0;
    {lk0_reg, lk1_reg, ul0_reg, ul1_reg, rd0_reg, rd1_reg} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy", busy, 16'h0000);
    chk("R1 sr_busy", {15'd0, sr_busy}, 16'h0);
    chk("R1 stall", {15'd0, stall}, 16'h0);
  endtask

  task automatic t_lock_unlock();
    do_reset();
    lk0_vld = 1; lk0_reg = 4'd3;
    step();
    chk("R2 single lock port0", busy, 16'h0008);
    lk1_vld = 1; lk1_reg = 4'd15;
    step();
    chk("R2 single lock port1", busy, 16'h8008);
    lk0_vld = 1; lk0_reg = 4'd0; lk1_vld = 1; lk1_reg = 4'd9;
    step();
    chk("R2 dual lock", busy, 16'h8209);
    ul0_vld = 1; ul0_reg = 4'd3; ul1_vld = 1; ul1_reg = 4'd15;
    step();
    chk("R3 dual unlock", busy, 16'h0201);
    ul1_vld = 1; ul1_reg = 4'd9;
    step();
    chk("R3 single unlock port1", busy, 16'h0001);
  endtask

  task automatic t_sr();
    do_reset();
    lk_sr = 1;
    step();
    chk("R4 sr lock", {15'd0, sr_busy}, 16'h1);
    chk("R4 sr lock no gpr", busy, 16'h0000);
    ul_sr = 1;
    step();
    chk("R4 sr unlock", {15'd0, sr_busy}, 16'h0);
    lk_sr = 1; ul_sr = 1;
    step();
    chk("R6 sr lock wins", {15'd0, sr_busy}, 16'h1);
  endtask

  task automatic t_stall();
    do_reset();
    rd0_vld = 1; rd0_reg = 4'd5; rd_sr = 1;
    #1 chk("R5 nothing busy", {15'd0, stall}, 16'h0);
    clear_in();
    lk0_vld = 1; lk0_reg = 4'd5; lk_sr = 1;
    step();
    rd0_vld = 1; rd0_reg = 4'd5;
    #1 chk("R5 src0 hit", {15'd0, stall}, 16'h1);
    rd0_reg = 4'd6;
    #1 chk("R5 src0 miss", {15'd0, stall}, 16'h0);
    rd0_vld = 0; rd1_vld = 1; rd1_reg = 4'd5;
    #1 chk("R5 src1 hit", {15'd0, stall}, 16'h1);
    rd1_vld = 0; rd_sr = 1;
    #1 chk("R5 sr hit", {15'd0, stall}, 16'h1);
    rd_sr = 0; rd0_reg = 4'd5;
    #1 chk("R9 invalid query", {15'd0, stall}, 16'h0);
    clear_in();
  endtask

  task automatic t_stall_blocks();
    do_reset();
    lk0_vld = 1; lk0_reg = 4'd2;
    step();
    rd0_vld = 1; rd0_reg = 4'd2;
    lk0_vld = 1; lk0_reg = 4'd9; lk1_vld = 1; lk1_reg = 4'd11; lk_sr = 1;
    step();
    chk("R7 stalled lock ignored", busy, 16'h0004);
    chk("R7 stalled sr lock ignored", {15'd0, sr_busy}, 16'h0);
    lk0_vld = 1; lk0_reg = 4'd9;
    step();
    chk("R7 lock after stall", busy, 16'h0204);
  endtask

  task automatic t_lock_wins();
    do_reset();
    lk0_vld = 1; lk0_reg = 4'd4;
    step();
    ul0_vld = 1; ul0_reg = 4'd4; lk1_vld = 1; lk1_reg = 4'd4;
    step();
    chk("R6 lock wins", busy, 16'h0010);
  endtask

  task automatic t_stale_invalid();
    do_reset();
    lk0_vld = 1; lk0_reg = 4'd1;
    step();
    ul0_vld = 1; ul0_reg = 4'd10; ul1_vld = 1; ul1_reg = 4'd11; ul_sr = 1;
    step();
    chk("R8 stale unlock", busy, 16'h0002);
    chk("R8 stale sr unlock", {15'd0, sr_busy}, 16'h0);
    lk0_reg = 4'd6; lk1_reg = 4'd7; ul0_reg = 4'd1; ul1_reg = 4'd1;
    step();
    chk("R9 invalid strobes", busy, 16'h0002);
  endtask

  initial begin
    clear_in();
    rst_n = 1'b0;
    t_reset();
    t_lock_unlock();
    t_sr();
    t_stall();
    t_stall_blocks();
    t_lock_wins();
    t_stale_invalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule